// File: doc/BRIEF.md
# Dual-Compare Pulse Output Unit

This block drives one output pin from a pair of compare values matched against a shared time base. The primary compare value marks the cycle where the pin goes high, and the secondary value marks the cycle where it goes low and raises a sticky interrupt flag. The time base is one of two internal up-counters. Each counter has its own period register and run bit, and it wraps to zero on the cycle it equals its period.

Software sets up the block through a small write-only register port. A control write picks the pulse mode and the counter. In single mode the block produces one pulse and then stays quiet until the control word is written again. In train mode the rise/fall sequence repeats in every counter period. Re-arming needs neither a stop of the counter nor a clear of the counter.

Top module: `pulse_cmp_unit`

## Requirements
- R1: After reset the pin and the flag are 0, both counters hold zero and are stopped, both compare values are zero and both periods are all ones.
- R2: A write to address 0 sets the mode from data bits 2:0 and the counter select from data bit 3. The pin is low in the cycle after such a write, and a stopped single pulse is re-armed, whatever the counter value.
- R3: In an active mode, when the selected counter is running and equals the primary value (address 1) at a clock edge, the pin is high after that edge.
- R4: When the selected running counter equals the secondary value (address 2) at a clock edge in an active mode, the pin is low and the flag is 1 after that edge.
- R5: When both compare values match at the same edge, the falling action wins: the pin stays low and the flag is set.
- R6: Mode code 3'b100 (single) gives at most one pulse per control write. After its falling edge no further rise or flag set occurs, however often the counter matches again.
- R7: Mode code 3'b101 (train) gives one pulse per counter period. A counter that equals its period at a running edge becomes 0 at that edge, and otherwise it adds one.
- R8: Address 3 holds the period of counter 0 and address 4 the period of counter 1. At address 5, data bit i is the run bit of counter i. A stopped counter holds its value and produces no compare actions. Only the counter chosen by the select bit drives the compares.
- R9: Mode code 3'b000 and every code other than 3'b100 and 3'b101 hold the pin low and never set the flag.
- R10: Writing address 6 with data bit 0 set clears the flag, and writing it with bit 0 clear leaves the flag unchanged. If a falling match occurs in the same cycle as a clear, the flag stays set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Synchronous reset, active low |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 3 | Register address |
| wr_data | input | 16 | Register write data |
| pulse_o | output | 1 | Pulse output pin |
| irq_flag_o | output | 1 | Sticky interrupt flag |

## Verification
A wrong one-shot state shows up as an extra rise on the pin at the next primary match. That comes within one counter period of the bad state. A wrong counter value or wrap shows as a shifted rise or fall edge in the very cycle it matters. A wrong flag priority shows on the flag one cycle after the clear that collides with a falling match. The bench compares both outputs against a behavioural model on every cycle, so any such divergence is reported within one clock of reaching the pin.

// File: rtl/pcu_pkg.sv
package pcu_pkg;

  typedef enum logic [2:0] {
    PCU_OFF   = 3'b000,
    PCU_ONCE  = 3'b100,
    PCU_TRAIN = 3'b101
  } pcu_mode_e;

  // field positions inside the control word
  localparam int unsigned CTL_MODE_LSB = 0;
  localparam int unsigned CTL_SEL_LSB  = 3;

  function automatic logic is_pulse_mode(input logic [2:0] code);
    return (code == PCU_ONCE) || (code == PCU_TRAIN);
  endfunction

  function automatic logic is_single_mode(input logic [2:0] code);
    return code == PCU_ONCE;
  endfunction

endpackage

// File: rtl/pcu_timebase.sv
module pcu_timebase #(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             run,
  input  logic [CNT_W-1:0] period,
  output logic [CNT_W-1:0] count
);

  localparam logic [CNT_W-1:0] ONE = {{(CNT_W-1){1'b0}}, 1'b1};

  function automatic logic [CNT_W-1:0] advance(input logic [CNT_W-1:0] cur,
                                               input logic [CNT_W-1:0] lim);
    return (cur == lim) ? '0 : cur + ONE;
  endfunction

  always_ff @(posedge clk) begin
    if (!rst_n)   count <= '0;
    else if (run) count <= advance(count, period);
  end

endmodule

// File: rtl/pcu_regs.sv
module pcu_regs
  import pcu_pkg::*;
#(
  parameter int CNT_W  = 16,
  parameter int NUM_TB = 2,
  parameter int ADDR_W = 3,
  parameter int SEL_W  = 1
) (
  input  logic                          clk,
  input  logic                          rst_n,
  input  logic                          wr_en,
  input  logic [ADDR_W-1:0]             wr_addr,
  input  logic [CNT_W-1:0]              wr_data,
  output logic [2:0]                    mode_q,
  output logic [SEL_W-1:0]              sel_q,
  output logic [CNT_W-1:0]              pri_q,
  output logic [CNT_W-1:0]              sec_q,
  output logic [NUM_TB-1:0][CNT_W-1:0]  per_q,
  output logic [NUM_TB-1:0]             run_q,
  output logic                          arm_wr,
  output logic                          flag_clr
);

  localparam int A_CTRL = 0;
  localparam int A_PRI  = 1;
  localparam int A_SEC  = 2;
  localparam int A_PER0 = 3;
  localparam int A_RUN  = A_PER0 + NUM_TB;
  localparam int A_CLR  = A_RUN + 1;

  function automatic logic hit(input logic en, input logic [ADDR_W-1:0] a, input int target);
    return en && (a == ADDR_W'(target));
  endfunction

  assign arm_wr   = hit(wr_en, wr_addr, A_CTRL);
  assign flag_clr = hit(wr_en, wr_addr, A_CLR) && wr_data[0];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      mode_q <= PCU_OFF;
      sel_q  <= '0;
      pri_q  <= '0;
      sec_q  <= '0;
      run_q  <= '0;
    end else begin
      if (arm_wr) begin
        mode_q <= wr_data[CTL_MODE_LSB +: 3];
        sel_q  <= wr_data[CTL_SEL_LSB +: SEL_W];
      end
      if (hit(wr_en, wr_addr, A_PRI)) pri_q <= wr_data;
      if (hit(wr_en, wr_addr, A_SEC)) sec_q <= wr_data;
      if (hit(wr_en, wr_addr, A_RUN)) run_q <= wr_data[NUM_TB-1:0];
    end
  end

  for (genvar t = 0; t < NUM_TB; t++) begin : g_per
    always_ff @(posedge clk) begin
      if (!rst_n)                          per_q[t] <= '1;
      else if (hit(wr_en, wr_addr, A_PER0 + t)) per_q[t] <= wr_data;
    end
  end

endmodule

// File: rtl/pcu_edge_fsm.sv
module pcu_edge_fsm
  import pcu_pkg::*;
#(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [2:0]       mode,
  input  logic [CNT_W-1:0] cnt,
  input  logic             cnt_run,
  input  logic [CNT_W-1:0] pri,
  input  logic [CNT_W-1:0] sec,
  input  logic             arm_wr,
  input  logic             flag_clr,
  output logic             pulse,
  output logic             flag,
  output logic             spent,
  output logic             rise_ev,
  output logic             fall_ev
);

  logic live;

  assign live    = is_pulse_mode(mode) && !(is_single_mode(mode) && spent)
                   && cnt_run && !arm_wr;
  assign rise_ev = live && (cnt == pri);
  assign fall_ev = live && (cnt == sec);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      pulse <= 1'b0;
      spent <= 1'b0;
    end else if (arm_wr) begin
      pulse <= 1'b0;
      spent <= 1'b0;
    end else if (!is_pulse_mode(mode)) begin
      pulse <= 1'b0;
    end else if (fall_ev) begin
      pulse <= 1'b0;
      spent <= is_single_mode(mode);
    end else if (rise_ev) begin
      pulse <= 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n)        flag <= 1'b0;
    else if (fall_ev)  flag <= 1'b1;
    else if (flag_clr) flag <= 1'b0;
  end

endmodule

// File: rtl/pulse_cmp_unit.sv
module pulse_cmp_unit
  import pcu_pkg::*;
#(
  parameter int CNT_W  = 16,
  parameter int NUM_TB = 2,
  parameter int ADDR_W = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [CNT_W-1:0]  wr_data,
  output logic              pulse_o,
  output logic              irq_flag_o
);

  localparam int SEL_W = (NUM_TB > 1) ? $clog2(NUM_TB) : 1;

  logic [2:0]                   mode_q;
  logic [SEL_W-1:0]             sel_q;
  logic [CNT_W-1:0]             pri_q;
  logic [CNT_W-1:0]             sec_q;
  logic [NUM_TB-1:0][CNT_W-1:0] per_q;
  logic [NUM_TB-1:0][CNT_W-1:0] cnt_all;
  logic [NUM_TB-1:0]            run_q;
  logic                         arm_wr;
  logic                         flag_clr;
  logic [CNT_W-1:0]             cnt_sel;
  logic                         run_sel;
  logic                         rise_ev;
  logic                         fall_ev;
  logic                         spent;

  pcu_regs #(
    .CNT_W(CNT_W), .NUM_TB(NUM_TB), .ADDR_W(ADDR_W), .SEL_W(SEL_W)
  ) u_regs (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .mode_q(mode_q), .sel_q(sel_q), .pri_q(pri_q), .sec_q(sec_q),
    .per_q(per_q), .run_q(run_q), .arm_wr(arm_wr), .flag_clr(flag_clr)
  );

  for (genvar t = 0; t < NUM_TB; t++) begin : g_tb
    pcu_timebase #(.CNT_W(CNT_W)) u_tb (
      .clk(clk), .rst_n(rst_n), .run(run_q[t]), .period(per_q[t]), .count(cnt_all[t])
    );
  end

  assign cnt_sel = cnt_all[sel_q];
  assign run_sel = run_q[sel_q];

  pcu_edge_fsm #(.CNT_W(CNT_W)) u_fsm (
    .clk(clk), .rst_n(rst_n), .mode(mode_q), .cnt(cnt_sel), .cnt_run(run_sel),
    .pri(pri_q), .sec(sec_q), .arm_wr(arm_wr), .flag_clr(flag_clr),
    .pulse(pulse_o), .flag(irq_flag_o), .spent(spent),
    .rise_ev(rise_ev), .fall_ev(fall_ev)
  );

endmodule

// File: rtl/pcu_checker.sv
module pcu_checker (
  input logic       clk,
  input logic       rst_n,
  input logic       pulse,
  input logic       flag,
  input logic       rise_ev,
  input logic       fall_ev,
  input logic       arm_wr,
  input logic       flag_clr,
  input logic       spent,
  input logic [2:0] mode
);

  AST_ARM_DRIVES_LOW: assert property (@(posedge clk) disable iff (!rst_n)
    arm_wr |=> !pulse); // R2

  AST_RISE_DRIVES_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
    rise_ev && !fall_ev |=> pulse); // R3

  AST_HIGH_NEEDS_RISE: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(pulse) |-> $past(rise_ev)); // R3

  AST_FALL_DRIVES_LOW: assert property (@(posedge clk) disable iff (!rst_n)
    fall_ev |=> !pulse && flag); // R4

  AST_FALL_BEATS_RISE: assert property (@(posedge clk) disable iff (!rst_n)
    rise_ev && fall_ev |=> !pulse); // R5

  AST_SINGLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    spent |-> !pulse && !rise_ev && !fall_ev); // R6

  AST_IDLE_LOW: assert property (@(posedge clk) disable iff (!rst_n)
    !(mode == 3'b100 || mode == 3'b101) |-> !pulse && !fall_ev); // R9

  AST_FLAG_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    flag && !flag_clr |=> flag); // R10

  AST_SET_BEATS_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
    fall_ev && flag_clr |=> flag); // R10

endmodule

bind pulse_cmp_unit pcu_checker u_chk (
  .clk(clk), .rst_n(rst_n), .pulse(pulse_o), .flag(irq_flag_o),
  .rise_ev(rise_ev), .fall_ev(fall_ev), .arm_wr(arm_wr), .flag_clr(flag_clr),
  .spent(spent), .mode(mode_q)
);

// File: tb/sim_pulse_cmp_unit.sv
`timescale 1ns/1ps
module sim_pulse_cmp_unit;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        wr_en = 1'b0;
  logic [2:0]  wr_addr = '0;
  logic [15:0] wr_data = '0;
  logic        pulse_o;
  logic        irq_flag_o;

  int compared = 0;
  int mismatched = 0;
  bit ended = 0;
  string cur_req = "R1";

  // behavioural reference state
  int m_cnt[2];
  int m_per[2];
  bit m_run[2];
  int m_pri, m_sec, m_mode, m_sel;
  bit m_spent, m_pulse, m_flag;

  always #10 clk = ~clk;

  pulse_cmp_unit u0 (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .pulse_o(pulse_o), .irq_flag_o(irq_flag_o)
  );

  task automatic check(input string req, input int act, input int exp, input string what);
    compared++;
    if (act != exp) begin
      mismatched++;
      $display("FAIL %s %s: actual %0d expected %0d at %0t", req, what, act, exp, $time);
    end
  endtask

  task automatic finish_run();
    if (!ended) begin
      ended = 1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
      $finish;
    end
  endtask

  // model: evaluated at each rising edge from the inputs applied before it
  always @(posedge clk) begin
    if (!rst_n) begin
      foreach (m_cnt[i]) begin m_cnt[i] = 0; m_per[i] = 65535; m_run[i] = 0; end
      m_pri = 0; m_sec = 0; m_mode = 0; m_sel = 0;
      m_spent = 0; m_pulse = 0; m_flag = 0;
    end else begin
      bit ctl_write, active, up, down, clear;
      ctl_write = wr_en && (wr_addr == 3'd0);
      clear     = wr_en && (wr_addr == 3'd6) && wr_data[0];
      active    = (m_mode == 5 || (m_mode == 4 && !m_spent)) && m_run[m_sel] && !ctl_write;
      up        = active && (m_cnt[m_sel] == m_pri);
      down      = active && (m_cnt[m_sel] == m_sec);
      if (ctl_write) begin
        m_pulse = 0; m_spent = 0;
      end else if (m_mode != 4 && m_mode != 5) begin
        m_pulse = 0;
      end else if (down) begin
        m_pulse = 0;
        if (m_mode == 4) m_spent = 1;
      end else if (up) begin
        m_pulse = 1;
      end
      if (down) m_flag = 1;
      else if (clear) m_flag = 0;
      for (int i = 0; i < 2; i++)
        if (m_run[i]) m_cnt[i] = (m_cnt[i] == m_per[i]) ? 0 : m_cnt[i] + 1;
      if (wr_en) begin
        case (wr_addr)
          3'd0: begin m_mode = int'(wr_data[2:0]); m_sel = int'(wr_data[3]); end
          3'd1: m_pri = int'(wr_data);
          3'd2: m_sec = int'(wr_data);
          3'd3: m_per[0] = int'(wr_data);
          3'd4: m_per[1] = int'(wr_data);
          3'd5: begin m_run[0] = wr_data[0]; m_run[1] = wr_data[1]; end
          default: ;
        endcase
      end
    end
  end

  // cycle-by-cycle comparison, away from the active edge
  always @(negedge clk) begin
    if (rst_n && !ended) begin
      check(cur_req, int'(pulse_o), int'(m_pulse), "pin vs model");
      check(cur_req, int'(irq_flag_o), int'(m_flag), "flag vs model");
    end
  end

  // called at a negedge; returns at the negedge after the write took effect
  task automatic wr(input int addr, input int data);
    wr_en   = 1'b1;
    wr_addr = 3'(addr);
    wr_data = 16'(data);
    @(negedge clk);
    wr_en   = 1'b0;
  endtask

  task automatic window(input int n, output int rises, output int highs);
    bit prev;
    prev = pulse_o;
    rises = 0;
    highs = 0;
    for (int k = 0; k < n; k++) begin
      @(negedge clk);
      if (pulse_o && !prev) rises++;
      if (pulse_o) highs++;
      prev = pulse_o;
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    mismatched++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    int rises, highs;
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    cur_req = "R1";
    check("R1", int'(pulse_o), 0, "pin after reset");
    check("R1", int'(irq_flag_o), 0, "flag after reset");

    // R6 single pulse, width from R3/R4
    cur_req = "R6";
    wr(1, 5); wr(2, 9); wr(3, 20);
    wr(0, 4'b0100);
    wr(5, 1);
    window(70, rises, highs);
    check("R6", rises, 1, "single-mode rises");
    check("R3", highs, 4, "high cycles between primary and secondary");
    check("R4", int'(irq_flag_o), 1, "flag after falling match");

    cur_req = "R10";
    wr(6, 0);
    check("R10", int'(irq_flag_o), 1, "flag after write with bit0 clear");
    wr(6, 1);
    check("R10", int'(irq_flag_o), 0, "flag after clear");

    // R2 re-arm with the counter still running
    cur_req = "R2";
    wr(0, 4'b0100);
    window(45, rises, highs);
    check("R2", rises, 1, "rises after re-arm");

    // R7 train mode: 84 edges = 4 periods of 21
    cur_req = "R7";
    wr(0, 4'b0101);
    window(84, rises, highs);
    check("R7", rises, 4, "train rises over four periods");

    cur_req = "R2";
    while (pulse_o !== 1'b1) @(negedge clk);
    wr(0, 4'b0101);
    check("R2", int'(pulse_o), 0, "pin after control write while high");

    // R8 counter select and run bits
    cur_req = "R8";
    wr(4, 12);
    wr(0, 4'b1101);
    window(40, rises, highs);
    check("R8", rises, 0, "rises with selected counter stopped");
    wr(5, 3);
    window(39, rises, highs);
    check("R8", rises, 3, "rises over three periods of 13");
    wr(5, 1);
    window(30, rises, highs);
    check("R8", rises, 0, "rises after selected counter paused");

    // R5 coincident matches
    cur_req = "R5";
    wr(1, 7); wr(2, 7);
    wr(0, 4'b1101);
    wr(6, 1);
    wr(5, 3);
    window(30, rises, highs);
    check("R5", rises, 0, "rises with equal compare values");
    check("R5", int'(irq_flag_o), 1, "flag with equal compare values");

    // R10 set beats clear in the same cycle
    cur_req = "R10";
    while (m_cnt[1] != 7) @(negedge clk);
    wr(6, 1);
    check("R10", int'(irq_flag_o), 1, "flag when clear meets falling match");

    // R9 disabled and unused codes
    cur_req = "R9";
    wr(1, 2); wr(2, 6);
    wr(0, 4'b1000);
    wr(6, 1);
    window(30, rises, highs);
    check("R9", rises, 0, "rises in off mode");
    check("R9", int'(irq_flag_o), 0, "flag in off mode");
    wr(0, 4'b1111);
    window(30, rises, highs);
    check("R9", highs, 0, "high cycles with unused code");
    check("R9", int'(irq_flag_o), 0, "flag with unused code");

    finish_run();
  end

endmodule